// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of a synchronous DRAM read or write burst. A command carries a starting column. The sequencer then puts out one column per clock, ordered by a stored mode. The mode selects a length of 2, 4, 8 or a whole page, and a beat order that is either counting or bit-flipping. A memory controller drives the command strobe and the starting column from its decoded column commands. It takes the column bus, the valid flag and the end-of-burst pulse back to its own timing logic.

Fixed-length bursts stay inside the aligned group of columns that contains the start, and the columns above that group are held. A page burst keeps counting and wraps at the top of the page until the controller ends it. A fresh command on any cycle, including the last beat, discards what is left of the current burst and starts the new one at full length.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset `col_valid`, `burst_done` and `mode_illegal` are 0, and the stored mode is length 2 with counting order.
- R2: When `cmd_start` is high at a clock edge, the next cycle shows `col_valid` = 1 and `col_out` equal to the sampled `cmd_col`. This is beat 0.
- R3: For a fixed length L (`mode_len` 0 = 2, 1 = 4, 2 = 8), the counting order (`mode_xor` = 0) gives beat k the low log2(L) bits (start + k) mod L. For example, L = 4 with low bits 2 gives 2, 3, 0, 1.
- R4: With `mode_xor` = 1 and a fixed length, beat k takes low bits equal to start XOR k. For example, L = 4 with low bits 1 gives 1, 0, 3, 2.
- R5: During a fixed-length burst, every `col_out` bit above the low log2(L) bits equals the starting column.
- R6: A fixed-length burst lasts exactly L valid beats. `burst_done` is 1 only on beat L-1, and `col_valid` is 0 on the next cycle unless a new command was accepted.
- R7: A page burst (`mode_len` = 3) adds one per beat, wraps from 2^COL_W-1 to 0, never raises `burst_done`, and stays valid until it is stopped or restarted.
- R8: When `cmd_stop` is high and `cmd_start` is low at an edge, `col_valid` is 0 on the next cycle. `cmd_start` wins if both are high.
- R9: With `mode_len` = 3 and `mode_xor` = 1 stored, `mode_illegal` is 1 and the page burst uses the counting order.
- R10: A command accepted during a burst drops the remaining beats. The new burst starts at its own column and runs its full length.
- R11: The mode is stored from `mode_len`/`mode_xor` when `mode_wr` is high, `col_valid` is 0 and `cmd_start` is 0. At any other time `mode_wr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Store the mode fields (only while idle) |
| mode_len | input | 2 | Length code: 0=2, 1=4, 2=8, 3=page |
| mode_xor | input | 1 | 1 selects bit-flip (XOR) order |
| cmd_start | input | 1 | Begin a new burst |
| cmd_col | input | COL_W | Starting column of the new burst |
| cmd_stop | input | 1 | End the current burst |
| col_out | output | COL_W | Column for the current beat |
| col_valid | output | 1 | A burst beat is being presented |
| burst_done | output | 1 | Last beat of a fixed-length burst |
| mode_illegal | output | 1 | Stored mode combines page length with XOR order |

## Verification
The bench builds the sequencer with COL_W = 5, so a page holds 32 columns. At that size a page burst reaches its wrap from column 31 to 0 within a few dozen cycles, both from directed stimulus and from random runs that are not stopped early. The two upper column bits still lie above the widest fixed group, so the rule that high bits are held is exercised for every length. Random commands, stops and mode writes land on every beat position, which covers restarts on the last beat, stop and start in the same cycle, and mode writes that arrive while a burst is active.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;

   typedef enum logic [1:0] {
      BL_2    = 2'd0,
      BL_4    = 2'd1,
      BL_8    = 2'd2,
      BL_PAGE = 2'd3
   } blen_e;

   typedef struct packed {
      blen_e len;
      logic  xor_ord;
   } mode_t;

   localparam mode_t MODE_RESET = '{len: BL_2, xor_ord: 1'b0};

   // Number of column bits that take part in the ordering of a fixed burst.
   function automatic int unsigned low_bits(blen_e len);
      case (len)
         BL_2:    return 1;
         BL_4:    return 2;
         BL_8:    return 3;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/col_seq_mode.sv
module col_seq_mode
   import col_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] len_in,
   input  logic       xor_in,
   input  logic       busy,
   input  logic       start,
   output mode_t      mode_o,
   output logic       illegal_o
);

   mode_t mode_q;
   logic  take;

   assign take = wr && !busy && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
      end else if (take) begin
         mode_q.len     <= blen_e'(len_in);
         mode_q.xor_ord <= xor_in;
      end
   end

   assign mode_o    = mode_q;
   assign illegal_o = (mode_q.len == BL_PAGE) && mode_q.xor_ord;

   // R11: a write during a burst, or alongside a command, leaves the mode alone
   p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || start) |=> $stable(mode_q));

   // R11: an idle write is stored on the next edge
   p_mode_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !busy && !start) |=> (mode_q.len == blen_e'($past(len_in))
                                   && mode_q.xor_ord == $past(xor_in)));

endmodule

// File: rtl/col_seq_ctrl.sv
module col_seq_ctrl
   import col_seq_pkg::*;
#(
   parameter int unsigned COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [COL_W-1:0] start_col,
   input  mode_t            mode,
   output logic             active_o,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] base_o,
   output logic             done_o
);

   logic             active_q;
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] base_q;
   logic             fixed_len;
   logic [COL_W-1:0] last_idx;
   logic             at_last;

   assign fixed_len = (mode.len != BL_PAGE);
   assign last_idx  = COL_W'((1 << low_bits(mode.len)) - 1);
   assign at_last   = fixed_len && (beat_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         beat_q   <= '0;
         base_q   <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         beat_q   <= '0;
         base_q   <= start_col;
      end else if (stop) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         if (at_last) begin
            active_q <= 1'b0;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   assign active_o = active_q;
   assign beat_o   = beat_q;
   assign base_o   = base_q;
   assign done_o   = active_q && at_last;

   // R6: the beat after the final one is idle unless a command restarts
   p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start) |=> !active_q);

   // R7: page bursts never signal completion
   p_page_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.len == BL_PAGE) |-> !done_o);

   // R10: a command always restarts at beat zero
   p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (active_q && beat_q == '0));

endmodule

// File: rtl/col_seq_addr.sv
module col_seq_addr
   import col_seq_pkg::*;
#(
   parameter int unsigned COL_W = 9
) (
   input  mode_t            mode,
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] wrap_mask;
   logic [COL_W-1:0] seq_col;
   logic [COL_W-1:0] xor_col;
   logic             use_xor;

   // Page length owns every bit; fixed lengths own only the low group.
   assign wrap_mask = (mode.len == BL_PAGE) ? '1
                    : COL_W'((1 << low_bits(mode.len)) - 1);
   assign seq_col   = base + beat;
   assign xor_col   = base ^ beat;
   // The XOR order is refused for page length; counting is used instead.
   assign use_xor   = mode.xor_ord && (mode.len != BL_PAGE);

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      always_comb begin
         if (!wrap_mask[i]) begin
            col_o[i] = base[i];
         end else if (use_xor) begin
            col_o[i] = xor_col[i];
         end else begin
            col_o[i] = seq_col[i];
         end
      end
   end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
   import col_seq_pkg::*;
#(
   parameter int unsigned COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic [1:0]       mode_len,
   input  logic             mode_xor,
   input  logic             cmd_start,
   input  logic [COL_W-1:0] cmd_col,
   input  logic             cmd_stop,
   output logic [COL_W-1:0] col_out,
   output logic             col_valid,
   output logic             burst_done,
   output logic             mode_illegal
);

   localparam int unsigned FIXED_MAX_W = 3;

   if (COL_W < FIXED_MAX_W + 1) begin : g_col_w_check
      $error("COL_W must exceed the widest fixed burst group");
   end

   mode_t            mode;
   logic             active;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] base;

   col_seq_mode u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (mode_wr),
      .len_in    (mode_len),
      .xor_in    (mode_xor),
      .busy      (active),
      .start     (cmd_start),
      .mode_o    (mode),
      .illegal_o (mode_illegal)
   );

   col_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd_start),
      .stop      (cmd_stop),
      .start_col (cmd_col),
      .mode      (mode),
      .active_o  (active),
      .beat_o    (beat),
      .base_o    (base),
      .done_o    (burst_done)
   );

   col_seq_addr #(.COL_W(COL_W)) u_addr (
      .mode  (mode),
      .base  (base),
      .beat  (beat),
      .col_o (col_out)
   );

   assign col_valid = active;

   // R2: the first beat is the commanded column
   p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> (col_valid && col_out == $past(cmd_col)));

   // R8: a stop without a command ends the burst
   p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stop && !cmd_start) |=> !col_valid);

   // R7: consecutive page beats step by one, wrapping at the page top
   p_page_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && $past(col_valid) && !$past(cmd_start)
       && mode.len == BL_PAGE && $past(mode.len) == BL_PAGE)
      |-> col_out == COL_W'($past(col_out) + 1'b1));

   // R5: columns above the ordering group match the burst's starting column
   p_high_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && mode.len != BL_PAGE)
      |-> col_out[COL_W-1:FIXED_MAX_W] == base[COL_W-1:FIXED_MAX_W]);

endmodule

// File: tb/sim_sdram_col_seq.sv
module sim_sdram_col_seq;

   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_wr = 1'b0;
   logic [1:0]    mode_len = 2'd0;
   logic          mode_xor = 1'b0;
   logic          cmd_start = 1'b0;
   logic [CW-1:0] cmd_col = '0;
   logic          cmd_stop = 1'b0;
   logic [CW-1:0] col_out;
   logic          col_valid;
   logic          burst_done;
   logic          mode_illegal;

   int vectors = 0;
   int errors = 0;
   bit finished = 0;

   // bench model state
   bit          m_act = 0;
   logic [CW-1:0] m_beat = '0;
   logic [CW-1:0] m_base = '0;
   int          m_len = 0;
   bit          m_xor = 0;

   always #2 clk = ~clk;

   sdram_col_seq #(.COL_W(CW)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_wr      (mode_wr),
      .mode_len     (mode_len),
      .mode_xor     (mode_xor),
      .cmd_start    (cmd_start),
      .cmd_col      (cmd_col),
      .cmd_stop     (cmd_stop),
      .col_out      (col_out),
      .col_valid    (col_valid),
      .burst_done   (burst_done),
      .mode_illegal (mode_illegal)
   );

   function automatic logic [CW-1:0] ref_col(logic [CW-1:0] b, logic [CW-1:0] k,
                                             int len, bit x);
      logic [CW-1:0] m;
      if (len == 3) return CW'(b + k);
      m = CW'((1 << (len + 1)) - 1);
      if (x) return (b & ~m) | ((b ^ k) & m);
      return (b & ~m) | (CW'(b + k) & m);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Advance one edge, update the model from the held inputs, compare.
   task automatic tick();
      bit was_act;
      bit last;
      @(posedge clk);
      #1;
      was_act = m_act;
      last = (m_len != 3) && (int'(m_beat) == (2 << m_len) - 1);
      if (cmd_start) begin
         m_act = 1; m_beat = '0; m_base = cmd_col;
      end else if (cmd_stop) begin
         m_act = 0;
      end else if (m_act) begin
         if (last) m_act = 0;
         else m_beat = m_beat + 1'b1;
      end
      if (mode_wr && !was_act && !cmd_start) begin
         m_len = int'(mode_len); m_xor = mode_xor;
      end
      chk("R2/R6/R8 valid", int'(col_valid), int'(m_act));
      chk("R6 done", int'(burst_done),
          int'(m_act && m_len != 3 && int'(m_beat) == (2 << m_len) - 1));
      chk("R9 illegal", int'(mode_illegal), int'(m_len == 3 && m_xor));
      if (m_act)
         chk(m_len == 3 ? "R7 page col" : (m_xor ? "R4 xor col" : "R3 seq col"),
             int'(col_out), int'(ref_col(m_base, m_beat, m_len, m_xor)));
   endtask

   task automatic set_mode(input int len, input bit x);
      mode_wr = 1; mode_len = 2'(len); mode_xor = x;
      tick();
      mode_wr = 0;
   endtask

   task automatic launch(input int col);
      cmd_start = 1; cmd_col = CW'(col);
      tick();
      cmd_start = 0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state
      chk("R1 valid", int'(col_valid), 0);
      chk("R1 done", int'(burst_done), 0);
      chk("R1 illegal", int'(mode_illegal), 0);
      tick();

      // R1: default mode is length 2, counting; start 3 gives 3, 2
      launch(3);
      chk("R1 beat0", int'(col_out), 3);
      tick();
      chk("R1 beat1", int'(col_out), 2);
      chk("R6 done len2", int'(burst_done), 1);
      tick();
      chk("R6 idle after", int'(col_valid), 0);

      // R3 and R5: length 4, start 22 (low 2) gives 22, 23, 20, 21
      set_mode(1, 0);
      launch(22);
      chk("R3 b0", int'(col_out), 22);
      tick(); chk("R3 b1", int'(col_out), 23);
      tick(); chk("R5 b2", int'(col_out), 20);
      tick(); chk("R5 b3", int'(col_out), 21);
      chk("R6 done len4", int'(burst_done), 1);
      tick();

      // R4: XOR order, length 4, start 1 gives 1, 0, 3, 2
      set_mode(1, 1);
      launch(1);
      chk("R4 b0", int'(col_out), 1);
      tick(); chk("R4 b1", int'(col_out), 0);
      // R11: mode write during the burst must not change the order
      mode_wr = 1; mode_len = 2'd3; mode_xor = 0;
      tick(); chk("R11 b2", int'(col_out), 3);
      mode_wr = 0;
      tick(); chk("R4 b3", int'(col_out), 2);
      tick();
      chk("R11 mode kept", int'(mode_illegal), 0);

      // R10: restart in the middle of a length-8 burst
      set_mode(2, 0);
      launch(13);
      tick(); chk("R10 pre", int'(col_out), 14);
      launch(6);
      chk("R10 restart", int'(col_out), 6);
      for (int i = 1; i < 8; i++) tick();
      chk("R10 full length", int'(col_out), 5);
      chk("R10 done", int'(burst_done), 1);
      tick();

      // R9 and R7: page with XOR requested wraps 30, 31, 0, 1 counting
      set_mode(3, 1);
      chk("R9 flag", int'(mode_illegal), 1);
      launch(30);
      tick(); chk("R7 b1", int'(col_out), 31);
      tick(); chk("R7 wrap", int'(col_out), 0);
      tick(); chk("R9 seq", int'(col_out), 1);
      for (int i = 0; i < 40; i++) tick();
      chk("R7 still valid", int'(col_valid), 1);
      // R8: stop ends it
      cmd_stop = 1; tick(); cmd_stop = 0;
      chk("R8 stopped", int'(col_valid), 0);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         cmd_start = ($urandom_range(99) < 12);
         cmd_stop  = ($urandom_range(99) < 4);
         cmd_col   = CW'($urandom());
         mode_wr   = ($urandom_range(99) < 10);
         mode_len  = 2'($urandom());
         mode_xor  = 1'($urandom());
         tick();
      end
      cmd_start = 0; cmd_stop = 0; mode_wr = 0;
      tick();
      finish_run();
   end

endmodule